// File: doc/BRIEF.md
# CCD Readout Region Sequencer

This block tracks where a progressive-scan CCD frame currently stands while its samples are clocked out. It keeps a column position within the line and a row position within the frame. From those two positions it tags the current sample as one of three kinds: a dummy stage of the transfer registers, an optical-black pixel, or an effective pixel. Downstream logic uses the black tag to collect samples for black-level clamping and the effective tag to gate active video.

Each line starts with 19 horizontal dummy stages. Then come 3 leading black columns, 782 effective columns and 38 trailing black columns, so a line has 842 positions. Each frame starts with 5 vertical dummy rows. Then come 8 leading black rows, 582 effective rows and 2 trailing black rows, so a frame has 597 rows. A frame-start strobe and a line-start strobe restart the counters, and a pixel enable advances the column.

A mode input selects how far the row moves per line period. In the dual-output interlaced mode two adjacent rows leave the sensor at once, so each line advances the row by two. In the single-output mode each line advances the row by one. In dual mode the row index names the upper row of the pair, and that row decides the row class.

Top module: `ccd_region_seq`

## Requirements
- R1: After reset, row_idx and col_idx are 0, in_frame is 1 and dummy_flag is 1.
- R2: frame_start sets row_idx and col_idx to 0 on the next clock edge. It takes priority over line_start and pix_en in the same cycle.
- R3: In single-output mode (dual_mode = 0), line_start without frame_start sets col_idx to 0 and adds 1 to row_idx. It takes priority over pix_en.
- R4: In dual-output mode (dual_mode = 1), line_start without frame_start adds 2 to row_idx and sets col_idx to 0.
- R5: col_idx adds 1 on each pix_en cycle that has no strobe. It holds when pix_en is 0 and stops at 842, which is past the end of the line.
- R6: row_idx stops at 597, which is past the end of the frame. An advance that would go beyond 597 gives 597.
- R7: Column classes are: 0..18 dummy, 19..21 black, 22..803 effective, 804..841 black, and 842 outside.
- R8: Row classes are: 0..4 dummy, 5..12 black, 13..594 effective, 595..596 black, and 597 outside.
- R9: active_flag is 1 only when both the row and the column are effective. If either one is a dummy, dummy_flag is 1. Any other in-frame position gives black_flag = 1.
- R10: At most one of dummy_flag, black_flag and active_flag is 1. All three are 0, and in_frame is 0, when the row or the column is outside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Restart the frame at row 0, column 0 |
| line_start | input | 1 | Start the next line period |
| pix_en | input | 1 | One sample clocked out this cycle |
| dual_mode | input | 1 | 1: two rows per line period; 0: one row per line period |
| row_idx | output | 10 | Current row position, 0..597 |
| col_idx | output | 10 | Current column position, 0..842 |
| in_frame | output | 1 | Position lies inside the line and the frame |
| dummy_flag | output | 1 | Sample is a transfer-register dummy stage |
| black_flag | output | 1 | Sample is optical black |
| active_flag | output | 1 | Sample is an effective pixel |

## Verification
The counters are the only registers, and the flags decode them combinationally. Every index and flag therefore shows the effect of a strobe or an enable at the first sample after the rising edge that captured it, with no further delay. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each check lands exactly one edge after its stimulus. It sweeps every column of an effective row and every row at an effective column. It also tests strobe priority, holding without an enable, and both saturation points.

// File: rtl/ccd_region_pkg.sv
package ccd_region_pkg;

    // Class of one axis position along a line or down a frame
    typedef enum logic [2:0] {
        SEG_DUMMY    = 3'd0,
        SEG_LEAD_OB  = 3'd1,
        SEG_EFF      = 3'd2,
        SEG_TRAIL_OB = 3'd3,
        SEG_PAST     = 3'd4
    } seg_t;

    typedef struct packed {
        logic in_frame;
        logic dummy;
        logic black;
        logic active;
    } tag_t;

endpackage

// File: rtl/ccd_axis_counter.sv
module ccd_axis_counter #(
    parameter int LIMIT = 842,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic         dbl,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    localparam logic [W:0] LIMIT_V = (W+1)'(LIMIT);

    cnt_state_t st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + (dbl ? (W+1)'(2) : (W+1)'(1));
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (sum >= LIMIT_V) st_d.cnt = LIMIT_V[W-1:0];
            else                st_d.cnt = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/ccd_seg_decode.sv
module ccd_seg_decode
    import ccd_region_pkg::*;
#(
    parameter int N_DUMMY    = 19,
    parameter int N_LEAD_OB  = 3,
    parameter int N_EFF      = 782,
    parameter int N_TRAIL_OB = 38,
    parameter int W          = 10
) (
    input  logic [W-1:0] pos,
    output seg_t         seg
);
    localparam int END_DUMMY = N_DUMMY;
    localparam int END_LEAD  = END_DUMMY + N_LEAD_OB;
    localparam int END_EFF   = END_LEAD + N_EFF;
    localparam int END_TRAIL = END_EFF + N_TRAIL_OB;

    always_comb begin
        if (int'(pos) < END_DUMMY)      seg = SEG_DUMMY;
        else if (int'(pos) < END_LEAD)  seg = SEG_LEAD_OB;
        else if (int'(pos) < END_EFF)   seg = SEG_EFF;
        else if (int'(pos) < END_TRAIL) seg = SEG_TRAIL_OB;
        else                            seg = SEG_PAST;
    end

endmodule

// File: rtl/ccd_region_seq.sv
module ccd_region_seq
    import ccd_region_pkg::*;
#(
    parameter int H_DUMMY    = 19,
    parameter int H_OB_LEAD  = 3,
    parameter int H_EFF      = 782,
    parameter int H_OB_TRAIL = 38,
    parameter int V_DUMMY    = 5,
    parameter int V_OB_LEAD  = 8,
    parameter int V_EFF      = 582,
    parameter int V_OB_TRAIL = 2,
    localparam int LINE_LEN  = H_DUMMY + H_OB_LEAD + H_EFF + H_OB_TRAIL,
    localparam int FRAME_LEN = V_DUMMY + V_OB_LEAD + V_EFF + V_OB_TRAIL,
    localparam int COL_W     = $clog2(LINE_LEN + 1),
    localparam int ROW_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic             pix_en,
    input  logic             dual_mode,
    output logic [ROW_W-1:0] row_idx,
    output logic [COL_W-1:0] col_idx,
    output logic             in_frame,
    output logic             dummy_flag,
    output logic             black_flag,
    output logic             active_flag
);
    seg_t col_seg, row_seg;
    tag_t tag;

    // Column restarts on either strobe and steps by one sample
    ccd_axis_counter #(.LIMIT(LINE_LEN), .W(COL_W)) u_col_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_start | line_start),
        .adv   (pix_en),
        .dbl   (1'b0),
        .cnt_o (col_idx)
    );

    // Row restarts on frame start and steps once per line period
    ccd_axis_counter #(.LIMIT(FRAME_LEN), .W(ROW_W)) u_row_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_start),
        .adv   (line_start),
        .dbl   (dual_mode),
        .cnt_o (row_idx)
    );

    ccd_seg_decode #(
        .N_DUMMY(H_DUMMY), .N_LEAD_OB(H_OB_LEAD), .N_EFF(H_EFF),
        .N_TRAIL_OB(H_OB_TRAIL), .W(COL_W)
    ) u_col_dec (
        .pos (col_idx),
        .seg (col_seg)
    );

    ccd_seg_decode #(
        .N_DUMMY(V_DUMMY), .N_LEAD_OB(V_OB_LEAD), .N_EFF(V_EFF),
        .N_TRAIL_OB(V_OB_TRAIL), .W(ROW_W)
    ) u_row_dec (
        .pos (row_idx),
        .seg (row_seg)
    );

    // Outside beats dummy, dummy beats black, effective needs both axes
    always_comb begin
        tag = '0;
        if (col_seg != SEG_PAST && row_seg != SEG_PAST) begin
            tag.in_frame = 1'b1;
            if (col_seg == SEG_DUMMY || row_seg == SEG_DUMMY)
                tag.dummy = 1'b1;
            else if (col_seg == SEG_EFF && row_seg == SEG_EFF)
                tag.active = 1'b1;
            else
                tag.black = 1'b1;
        end
    end

    assign in_frame    = tag.in_frame;
    assign dummy_flag  = tag.dummy;
    assign black_flag  = tag.black;
    assign active_flag = tag.active;

endmodule

// File: rtl/ccd_region_seq_chk.sv
module ccd_region_seq_chk #(
    parameter int LINE_LEN  = 842,
    parameter int FRAME_LEN = 597,
    parameter int COL_W     = 10,
    parameter int ROW_W     = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             line_start,
    input logic             pix_en,
    input logic             dual_mode,
    input logic [ROW_W-1:0] row_idx,
    input logic [COL_W-1:0] col_idx,
    input logic             in_frame,
    input logic             dummy_flag,
    input logic             black_flag,
    input logic             active_flag
);
    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dummy_flag, black_flag, active_flag}));

    // R10
    flags_need_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> !(dummy_flag || black_flag || active_flag));

    // R2
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (row_idx == '0 && col_idx == '0));

    // R3
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start) |=> col_idx == '0);

    // R4
    dual_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && dual_mode && int'(row_idx) + 2 <= FRAME_LEN)
        |=> row_idx == ROW_W'($past(row_idx) + 2'd2));

    // R5
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !frame_start && !line_start && int'(col_idx) < LINE_LEN)
        |=> col_idx == COL_W'($past(col_idx) + 1'b1));

    // R5
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && !frame_start && !line_start) |=> $stable(col_idx));

    // R6
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_idx) <= FRAME_LEN);

endmodule

bind ccd_region_seq ccd_region_seq_chk #(
    .LINE_LEN(LINE_LEN), .FRAME_LEN(FRAME_LEN), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (.*);

// File: tb/ccd_region_seq_tb.sv
module ccd_region_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, line_start = 1'b0, pix_en = 1'b0, dual_mode = 1'b0;
    logic [9:0] row_idx, col_idx;
    logic       in_frame, dummy_flag, black_flag, active_flag;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    ccd_region_seq u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .pix_en(pix_en), .dual_mode(dual_mode), .row_idx(row_idx), .col_idx(col_idx),
        .in_frame(in_frame), .dummy_flag(dummy_flag), .black_flag(black_flag),
        .active_flag(active_flag)
    );

    // {in_frame, dummy, black, active} from the layout in R7/R8/R9/R10
    function automatic logic [3:0] model(int r, int c);
        if (r >= 597 || c >= 842) return 4'b0000;
        if (r < 5 || c < 19) return 4'b1100;
        if (r >= 13 && r < 595 && c >= 22 && c < 804) return 4'b1001;
        return 4'b1010;
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int flags();
        return int'({in_frame, dummy_flag, black_flag, active_flag});
    endfunction

    // Apply one cycle of inputs at the falling edge; outputs are read one edge later
    task automatic cyc(logic fs, logic ls, logic pe);
        frame_start = fs; line_start = ls; pix_en = pe;
        @(negedge clk);
        frame_start = 1'b0; line_start = 1'b0; pix_en = 1'b0;
    endtask

    task automatic goto_pos(int r, int c);
        dual_mode = 1'b0;
        cyc(1, 0, 0);
        repeat (r) cyc(0, 1, 0);
        repeat (c) cyc(0, 0, 1);
    endtask

    task automatic t_reset();
        chk("R1 row", row_idx, 0);
        chk("R1 col", col_idx, 0);
        chk("R1 flags", flags(), 4'b1100);
    endtask

    task automatic t_columns();
        goto_pos(20, 0);
        chk("R7 col0", flags(), model(20, 0));
        for (int c = 1; c <= 845; c++) begin
            cyc(0, 0, 1);
            chk(c > 842 ? "R5 col sat" : "R7 col idx", col_idx, c > 842 ? 842 : c);
            chk("R7 col flags", flags(), model(20, c > 842 ? 842 : c));
        end
        chk("R10 past line", flags(), 0);
    endtask

    task automatic t_rows();
        dual_mode = 1'b0;
        cyc(1, 0, 0);
        for (int r = 0; r <= 599; r++) begin
            if (r > 0) begin
                cyc(0, 1, 0);
                chk("R3 col clear", col_idx, 0);
            end
            chk(r > 597 ? "R6 row sat" : "R3 row step", row_idx, r > 597 ? 597 : r);
            repeat (30) cyc(0, 0, 1);
            chk("R8 row flags", flags(), model(r > 597 ? 597 : r, 30));
        end
    endtask

    task automatic t_dual();
        dual_mode = 1'b1;
        cyc(1, 0, 0);
        for (int k = 1; k <= 300; k++) begin
            cyc(0, 1, 0);
            chk("R4 dual row", row_idx, 2 * k > 597 ? 597 : 2 * k);
        end
        dual_mode = 1'b0;
    endtask

    task automatic t_priority();
        goto_pos(50, 300);
        cyc(1, 1, 1);
        chk("R2 row", row_idx, 0);
        chk("R2 col", col_idx, 0);
        goto_pos(50, 300);
        cyc(0, 1, 1);
        chk("R3 ls over pe col", col_idx, 0);
        chk("R3 ls over pe row", row_idx, 51);
    endtask

    task automatic t_hold();
        goto_pos(40, 500);
        repeat (5) cyc(0, 0, 0);
        chk("R5 hold col", col_idx, 500);
        chk("R5 hold row", row_idx, 40);
    endtask

    task automatic t_mixed();
        goto_pos(8, 400);   chk("R9 ob row eff col", flags(), 4'b1010);
        goto_pos(2, 400);   chk("R9 dummy row", flags(), 4'b1100);
        goto_pos(100, 20);  chk("R9 ob col eff row", flags(), 4'b1010);
        goto_pos(100, 400); chk("R9 both eff", flags(), 4'b1001);
        goto_pos(7, 10);    chk("R9 dummy col ob row", flags(), 4'b1100);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_columns();
        t_rows();
        t_dual();
        t_priority();
        t_hold();
        t_mixed();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule